// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is a clock-synchronous model of the command front end of a byte-wide flash device. A host issues byte writes (command or confirm code plus a 21-bit address) and read strobes. The controller decodes each written byte, keeps track of which source a read returns (memory array, identifier codes or status byte), and keeps an 8-bit status byte. Its error bits stay set until software clears them.

Block erase and page program are two-cycle sequences: a setup byte, then a confirm byte. The controller does not move any cell data. It runs each operation as a busy period of a fixed number of clock cycles and drives a ready/busy output for that period. At the end of the period, a pass/fail input from an external array model sets the matching error bit. A running operation can be suspended and later resumed, and the remaining count is kept across the suspension. A sleep command parks the controller until the next read-array command. Array reads are passed to the external model through a request port, and the model returns the byte on a data port in the same cycle.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While rst_ni is low, rdy_o is 1 and rdata_o is 00h. Reset aborts any running operation. After reset is released, reads return array data, and the status byte reads 80h (bit 7 = ready, every other bit 0).
- R2: After writing FFh, each read strobe raises arr_req_o in the same cycle with arr_addr_o = addr_i. rdata_o takes the value of arr_data_i at that clock edge.
- R3: After writing 90h, a read with addr_i[0]=0 returns 1Ch and a read with addr_i[0]=1 returns 69h.
- R4: After writing 70h, a read returns the status byte as it was at the clock edge that samples rd_i. rdata_o keeps that value until the next read strobe, even if the status changes in the meantime.
- R5: Writing 20h and then D0h starts an erase. rdy_o is 0 for exactly ERASE_CYC cycles, beginning the cycle after the confirm. op_blk_o holds addr_i[20:16] of the confirm write. Reads then return status. rdy_o only falls on a write of D0h.
- R6: Writing 0Eh and then D0h starts a program. rdy_o is 0 for exactly PROG_CYC cycles.
- R7: If op_fail_i is 1 when an operation finishes, the controller sets status bit 5 (erase) or bit 4 (program). These bits stay set through later operations until a write of 50h clears both of them.
- R8: In a setup sequence, any second byte other than D0h sets status bits 5 and 4 and selects array reads. No operation starts, and rdy_o stays 1.
- R9: Writing B0h while busy suspends the operation. On the next cycle rdy_o is 1 and the status byte reads C0h (bits 7 and 6 set), and the countdown holds. Writing D0h resumes the operation for the remaining cycles only.
- R10: While suspended, FFh, 90h and 70h select the read source. The setup bytes 20h and 0Eh are ignored and cause no sequence error.
- R11: When idle, a write of F0h enters sleep at once: status bit 0 is set and reads return status. When F0h is written during an operation, sleep starts when the operation finishes. Only a write of FFh leaves sleep. Any other write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (also deep power-down) |
| wr_i | input | 1 | Command/data write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Written byte |
| rdata_o | output | 8 | Read data, updated at the edge that samples rd_i |
| rdy_o | output | 1 | 1 = ready, 0 = operation running |
| op_blk_o | output | ADDR_W-BLK_LSB | Block of the last confirmed operation |
| arr_req_o | output | 1 | Array read request to the external model |
| arr_addr_o | output | ADDR_W | Array read address |
| arr_data_i | input | 8 | Array byte returned by the external model |
| op_fail_i | input | 1 | Operation result, sampled on the final busy cycle |

## Verification
The bench builds the controller with ERASE_CYC=12 and PROG_CYC=7. With these lengths, an erase can be suspended after two cycles and resumed for exactly ten more. A sleep request can be placed inside a program period, and the busy window can be measured exactly cycle by cycle. The 21-bit default address width is kept, so the block field is checked against the upper five address bits. A seeded random sequence of read-mode commands and addresses is checked against a bench model of the read source and of the sticky error bits.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OP_RD_ARR  = 8'hFF;
  localparam logic [7:0] OP_RD_ID   = 8'h90;
  localparam logic [7:0] OP_RD_SR   = 8'h70;
  localparam logic [7:0] OP_CLR_SR  = 8'h50;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROG    = 8'h0E;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_SLEEP   = 8'hF0;
  localparam logic [7:0] ID_MFR     = 8'h1C;
  localparam logic [7:0] ID_DEV     = 8'h69;

  typedef enum logic [3:0] {
    C_NONE, C_RD_ARR, C_RD_ID, C_RD_SR, C_CLR_SR,
    C_ERASE, C_PROG, C_CONFIRM, C_SUSPEND, C_SLEEP
  } cmd_e;

  typedef enum logic [1:0] {M_ARRAY, M_ID, M_STATUS} mode_e;
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RUN, S_SUSP, S_SLEEP} state_e;
  typedef enum logic [1:0] {K_NONE, K_ERASE, K_PROG} op_kind_e;
endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] byte_i,
  output cmd_e       cmd_o
);
  always_comb begin
    unique case (byte_i)
      OP_RD_ARR:  cmd_o = C_RD_ARR;
      OP_RD_ID:   cmd_o = C_RD_ID;
      OP_RD_SR:   cmd_o = C_RD_SR;
      OP_CLR_SR:  cmd_o = C_CLR_SR;
      OP_ERASE:   cmd_o = C_ERASE;
      OP_PROG:    cmd_o = C_PROG;
      OP_CONFIRM: cmd_o = C_CONFIRM;
      OP_SUSPEND: cmd_o = C_SUSPEND;
      OP_SLEEP:   cmd_o = C_SLEEP;
      default:    cmd_o = C_NONE;
    endcase
  end
endmodule

// File: rtl/fcc_timer.sv
module fcc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (load_i)                     cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  // last busy cycle; count holds while run_i is low (suspend)
  assign done_o = run_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fcc_core.sv
module fcc_core
  import flash_cmd_pkg::*;
#(
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 24,
  parameter int CNT_W     = 7,
  parameter int BLK_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  cmd_e             cmd_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             done_i,
  input  logic             fail_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             run_o,
  output mode_e            mode_o,
  output logic [7:0]       status_o,
  output logic [BLK_W-1:0] blk_o
);
  state_e   st_q;
  mode_e    mode_q;
  op_kind_e op_q;
  logic     err_erase_q, err_prog_q, sleep_pend_q;
  logic [BLK_W-1:0] blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= S_IDLE;
      mode_q       <= M_ARRAY;
      op_q         <= K_NONE;
      err_erase_q  <= 1'b0;
      err_prog_q   <= 1'b0;
      sleep_pend_q <= 1'b0;
      blk_q        <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (wr_i) begin
          unique case (cmd_i)
            C_RD_ARR: mode_q <= M_ARRAY;
            C_RD_ID:  mode_q <= M_ID;
            C_RD_SR:  mode_q <= M_STATUS;
            C_CLR_SR: begin err_erase_q <= 1'b0; err_prog_q <= 1'b0; end
            C_ERASE:  begin st_q <= S_SETUP; op_q <= K_ERASE; end
            C_PROG:   begin st_q <= S_SETUP; op_q <= K_PROG; end
            C_SLEEP:  begin st_q <= S_SLEEP; mode_q <= M_STATUS; end
            default: ;
          endcase
        end
        S_SETUP: if (wr_i) begin
          if (cmd_i == C_CONFIRM) begin
            st_q   <= S_RUN;
            mode_q <= M_STATUS;
            blk_q  <= blk_i;
          end else begin
            // broken sequence: flag both error bits, no operation
            st_q        <= S_IDLE;
            op_q        <= K_NONE;
            mode_q      <= M_ARRAY;
            err_erase_q <= 1'b1;
            err_prog_q  <= 1'b1;
          end
        end
        S_RUN: begin
          if (done_i) begin
            st_q         <= sleep_pend_q ? S_SLEEP : S_IDLE;
            sleep_pend_q <= 1'b0;
            op_q         <= K_NONE;
            if (fail_i) begin
              if (op_q == K_ERASE) err_erase_q <= 1'b1;
              else                 err_prog_q  <= 1'b1;
            end
          end else if (wr_i && cmd_i == C_SUSPEND) begin
            st_q <= S_SUSP;
          end else if (wr_i && cmd_i == C_SLEEP) begin
            sleep_pend_q <= 1'b1;
          end
        end
        S_SUSP: if (wr_i) begin
          unique case (cmd_i)
            C_RD_ARR:  mode_q <= M_ARRAY;
            C_RD_ID:   mode_q <= M_ID;
            C_RD_SR:   mode_q <= M_STATUS;
            C_CLR_SR:  begin err_erase_q <= 1'b0; err_prog_q <= 1'b0; end
            C_CONFIRM: begin st_q <= S_RUN; mode_q <= M_STATUS; end
            C_SLEEP:   sleep_pend_q <= 1'b1;
            default: ;
          endcase
        end
        S_SLEEP: if (wr_i && cmd_i == C_RD_ARR) begin
          st_q   <= S_IDLE;
          mode_q <= M_ARRAY;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign load_o     = (st_q == S_SETUP) && wr_i && (cmd_i == C_CONFIRM);
  assign load_val_o = (op_q == K_ERASE) ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
  assign run_o      = (st_q == S_RUN);
  assign mode_o     = mode_q;
  assign blk_o      = blk_q;
  assign status_o   = {st_q != S_RUN, st_q == S_SUSP, err_erase_q, err_prog_q,
                       3'b000, st_q == S_SLEEP};
endmodule

// File: rtl/fcc_rdmux.sv
module fcc_rdmux
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  mode_e      mode_i,
  input  logic       id_sel_i,
  input  logic [7:0] arr_data_i,
  input  logic [7:0] status_i,
  output logic [7:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= 8'h00;
    else if (rd_i) begin
      unique case (mode_i)
        M_ARRAY: rdata_o <= arr_data_i;
        M_ID:    rdata_o <= id_sel_i ? ID_DEV : ID_MFR;
        default: rdata_o <= status_i;  // captured at read start
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int BLK_LSB   = 16,
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [7:0]                wdata_i,
  output logic [7:0]                rdata_o,
  output logic                      rdy_o,
  output logic [ADDR_W-BLK_LSB-1:0] op_blk_o,
  output logic                      arr_req_o,
  output logic [ADDR_W-1:0]         arr_addr_o,
  input  logic [7:0]                arr_data_i,
  input  logic                      op_fail_i
);
  localparam int BLK_W   = ADDR_W - BLK_LSB;
  localparam int CNT_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  cmd_e             cmd_w;
  mode_e            mode_w;
  logic [7:0]       sr_w;
  logic             load_w, run_w, done_w;
  logic [CNT_W-1:0] load_val_w;

  fcc_decode u_dec (.byte_i(wdata_i), .cmd_o(cmd_w));

  fcc_core #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .CNT_W(CNT_W), .BLK_W(BLK_W)
  ) u_core (
    .clk_i, .rst_ni, .wr_i,
    .cmd_i      (cmd_w),
    .blk_i      (addr_i[ADDR_W-1:BLK_LSB]),
    .done_i     (done_w),
    .fail_i     (op_fail_i),
    .load_o     (load_w),
    .load_val_o (load_val_w),
    .run_o      (run_w),
    .mode_o     (mode_w),
    .status_o   (sr_w),
    .blk_o      (op_blk_o)
  );

  fcc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i     (load_w),
    .load_val_i (load_val_w),
    .run_i      (run_w),
    .done_o     (done_w)
  );

  fcc_rdmux u_rd (
    .clk_i, .rst_ni, .rd_i,
    .mode_i     (mode_w),
    .id_sel_i   (addr_i[0]),
    .arr_data_i (arr_data_i),
    .status_i   (sr_w),
    .rdata_o    (rdata_o)
  );

  assign rdy_o      = !run_w;
  assign arr_req_o  = rd_i && (mode_w == M_ARRAY);
  assign arr_addr_o = addr_i;
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       rdy_o,
  input logic       arr_req_o,
  input logic [7:0] status_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R1: assert (rdy_o && status_i == 8'h80 && rdata_o == 8'h00);
    end
  end

  assert_req_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_req_o |-> rd_i);

  assert_busy_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> ($past(wr_i) && $past(wdata_i) == 8'hD0));

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[5] && !(wr_i && wdata_i == 8'h50)) |=> status_i[5]);

  assert_suspend_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && wr_i && wdata_i == 8'hB0) |=> rdy_o);

  assert_resume_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[6] && wr_i && wdata_i == 8'hD0) |=> !rdy_o);

  assert_sleep_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[0] && !(wr_i && wdata_i == 8'hFF)) |=> status_i[0]);
endmodule

bind flash_cmd_ctrl fcc_checker u_chk (
  .clk_i, .rst_ni, .wr_i, .rd_i, .wdata_i, .rdata_o, .rdy_o, .arr_req_o,
  .status_i (sr_w)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int ERASE_N = 12;
  localparam int PROG_N  = 7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0, op_fail_i = 1'b0;
  logic [20:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o, arr_data_i;
  logic        rdy_o, arr_req_o;
  logic [4:0]  op_blk_o;
  logic [20:0] arr_addr_o;

  int checks = 0, errors = 0;
  bit reported = 0;
  logic        req_seen;
  logic [20:0] req_addr;

  always #4 clk = ~clk;

  function automatic logic [7:0] arr_fn(input logic [20:0] a);
    return a[7:0] ^ {a[15:11], a[18:16]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] exp_read(input int mode, input logic [20:0] a,
                                          input logic e5, input logic e4);
    case (mode)
      0:       return arr_fn(a);
      1:       return a[0] ? 8'h69 : 8'h1C;
      default: return {1'b1, 1'b0, e5, e4, 4'b0000};
    endcase
  endfunction

  assign arr_data_i = arr_fn(arr_addr_o);

  flash_cmd_ctrl #(.ERASE_CYC(ERASE_N), .PROG_CYC(PROG_N)) dut (
    .clk_i(clk), .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o, .rdy_o,
    .op_blk_o, .arr_req_o, .arr_addr_o, .arr_data_i, .op_fail_i
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [20:0] a, output logic [7:0] d);
    rd_i = 1'b1; addr_i = a;
    #1;
    req_seen = arr_req_o; req_addr = arr_addr_o;
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (rdy_o == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got hang exp finish");
    report();
  end

  initial begin
    logic [7:0] d;
    int n, mode;
    logic e5, e4;
    int unused_seed;
    unused_seed = $urandom(32'h1F2E3D4C);

    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 rdy in reset", rdy_o, 1);
    chk("R1 rdata in reset", rdata_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(21'h00123, d);
    chk("R1 array after reset", d, arr_fn(21'h00123));
    chk("R2 req raised", req_seen, 1);
    chk("R2 req addr", req_addr, 21'h00123);
    wr(0, 8'h70); rd(0, d);
    chk("R1 status after reset", d, 8'h80);

    // R3 identifier
    wr(0, 8'h90);
    rd(21'h0, d);     chk("R3 manufacturer", d, 8'h1C);
    chk("R3 no array req", req_seen, 0);
    rd(21'h1, d);     chk("R3 device", d, 8'h69);

    // R6 program with R4 capture
    op_fail_i = 1'b0;
    wr(0, 8'h0E); wr(21'h040000, 8'hD0);
    rd(0, d);         chk("R4 busy status", d, 8'h00);
    count_busy(n);    chk("R6 program busy length", n, PROG_N - 1);
    chk("R4 held until strobe", rdata_o, 8'h00);
    rd(0, d);         chk("R4 ready status", d, 8'h80);

    // R5 erase, R7 fail sticky
    op_fail_i = 1'b1;
    wr(0, 8'h20); wr(21'h1A3456, 8'hD0);
    chk("R5 block field", op_blk_o, 5'h1A);
    count_busy(n);    chk("R5 erase busy length", n, ERASE_N);
    rd(0, d);         chk("R7 erase fail", d, 8'hA0);
    op_fail_i = 1'b0;
    wr(0, 8'h20); wr(21'h020000, 8'hD0);
    count_busy(n);    chk("R5 second erase", n, ERASE_N);
    rd(0, d);         chk("R7 sticky", d, 8'hA0);
    wr(0, 8'h50); rd(0, d);
    chk("R7 cleared", d, 8'h80);
    op_fail_i = 1'b1;
    wr(0, 8'h0E); wr(0, 8'hD0);
    count_busy(n);
    rd(0, d);         chk("R7 program fail", d, 8'h90);
    op_fail_i = 1'b0;
    wr(0, 8'h50);

    // R8 sequence error
    wr(0, 8'h20); wr(0, 8'h70);
    chk("R8 stays ready", rdy_o, 1);
    rd(21'h0ABCD, d); chk("R8 array mode", d, arr_fn(21'h0ABCD));
    wr(0, 8'h70); rd(0, d);
    chk("R8 both error bits", d, 8'hB0);
    wr(0, 8'h50);
    wr(0, 8'h0E); wr(0, 8'hFF);
    chk("R8 program no start", rdy_o, 1);
    wr(0, 8'h70); rd(0, d);
    chk("R8 program seq error", d, 8'hB0);
    wr(0, 8'h50);

    // R9 / R10 suspend and resume
    wr(0, 8'h20); wr(0, 8'hD0);
    @(negedge clk);
    wr(0, 8'hB0);
    chk("R9 ready when suspended", rdy_o, 1);
    rd(0, d);         chk("R9 suspend status", d, 8'hC0);
    repeat (5) @(negedge clk);
    chk("R9 count frozen", rdy_o, 1);
    wr(0, 8'hFF);
    rd(21'h155AA, d); chk("R10 array in suspend", d, arr_fn(21'h155AA));
    wr(0, 8'h20); wr(0, 8'h70);
    rd(0, d);         chk("R10 setup ignored", d, 8'hC0);
    wr(0, 8'hD0);
    count_busy(n);    chk("R9 remaining cycles", n, ERASE_N - 2);
    rd(0, d);         chk("R9 done status", d, 8'h80);

    // R11 sleep
    wr(0, 8'hF0);
    rd(0, d);         chk("R11 sleep status", d, 8'h81);
    wr(0, 8'h90);
    rd(21'h1, d);     chk("R11 other write ignored", d, 8'h81);
    wr(0, 8'hFF);
    rd(21'h00777, d); chk("R11 exit to array", d, arr_fn(21'h00777));
    wr(0, 8'h0E); wr(0, 8'hD0);
    wr(0, 8'hF0);
    chk("R11 op continues", rdy_o, 0);
    count_busy(n);
    rd(0, d);         chk("R11 sleep after op", d, 8'h81);
    wr(0, 8'hFF);

    // R1 reset aborts an operation
    wr(0, 8'h20); wr(0, 8'hD0);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 abort ready", rdy_o, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(21'h0F0F0, d); chk("R1 array after abort", d, arr_fn(21'h0F0F0));
    wr(0, 8'h70); rd(0, d);
    chk("R1 status after abort", d, 8'h80);

    // random read-mode traffic: R2 R3 R4
    mode = 2; e5 = 1'b0; e4 = 1'b0;
    for (int i = 0; i < 60; i++) begin
      logic [20:0] a;
      int k;
      k = int'($urandom % 5);
      a = 21'($urandom);
      case (k)
        0: begin wr(a, 8'hFF); mode = 0; end
        1: begin wr(a, 8'h90); mode = 1; end
        2: begin wr(a, 8'h70); mode = 2; end
        3: begin wr(a, 8'h20); wr(a, 8'h55); mode = 0; e5 = 1; e4 = 1; end
        default: begin wr(a, 8'h50); e5 = 0; e4 = 0; end
      endcase
      a = 21'($urandom);
      rd(a, d);
      chk(mode == 0 ? "R2 random array" : mode == 1 ? "R3 random id" : "R4 random status",
          d, exp_read(mode, a, e5, e4));
    end

    report();
  end
endmodule